// File: doc/BRIEF.md
# Memory Bus Access Error Checker

This block sits on the slave side of an AHB-style system bus, in front of four external memory regions: a NOR flash region, two PC-card regions and an SDRAM region. The SDRAM region holds two devices. For every accepted read or write, the block decides whether the transfer may go on to the downstream memory controller or must end with a bus error. The decision rests on configuration values that arrive as plain inputs: an enable per region, a flash-access enable for the NOR region, a card-presence pin for the PC-card regions, and a write-protect bit per SDRAM device. It also checks the address against reserved holes in the SDRAM map.

The region is taken from the two address bits at `REGION_LSB`. Inside the SDRAM region, the bit below selects the device. The remaining low bits are an offset, and any offset at or above `SDRAM_DEV_BYTES` is reserved. A rejected transfer gets the standard two-cycle error response, and no external select is raised for it. An allowed transfer completes with zero wait states. It is presented one cycle later to the downstream controller as a single-cycle request with a one-hot region select.

Top module: `memacc_guard`

## Requirements
- R1: A NONSEQ or SEQ transfer (htrans 2'b10 or 2'b11) accepted while hsel and hready_in are high, to a region whose bank_en bit is 0, gets an error response. Region index = haddr[REGION_LSB+1:REGION_LSB]: 0 is NOR, 1 and 2 are PC card, 3 is SDRAM.
- R2: An accepted transfer to region 0 gets an error response while flash_acc_en is 0.
- R3: An accepted transfer to region 1 or 2 gets an error response while card_present is 0.
- R4: An accepted write to region 3 gets an error response when sdram_wp[dev] is 1, where dev = haddr[REGION_LSB-1]. A read under the same conditions is allowed.
- R5: An accepted transfer to region 3 gets an error response when its offset haddr[REGION_LSB-2:0] is at or above SDRAM_DEV_BYTES.
- R6: An error response lasts two cycles, starting the cycle after acceptance. In the first cycle hresp=1 and hready_out=0. In the second cycle hresp=1 and hready_out=1.
- R7: A rejected transfer never raises dn_req or any dn_sel bit.
- R8: An IDLE (2'b00) or BUSY (2'b01) transfer, or any transfer with hsel low, gets hresp=0 and hready_out=1 in the following cycle and raises no dn_req.
- R9: An allowed transfer gets hresp=0 and hready_out=1 in the following cycle. In that same cycle, dn_req=1, dn_sel has only bit [region] set, and dn_addr and dn_write equal the accepted haddr and hwrite.
- R10: After reset, hresp=0, hready_out=1, dn_req=0 and dn_sel=0.
- R11: A transfer presented during the second error cycle is accepted and checked like any other transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsel | input | 1 | Slave select |
| htrans | input | 2 | Transfer type |
| haddr | input | ADDR_W | Transfer address |
| hwrite | input | 1 | 1 = write, 0 = read |
| hready_in | input | 1 | Bus-wide ready, qualifies the address phase |
| bank_en | input | 4 | Per-region enable |
| flash_acc_en | input | 1 | Flash-access enable for region 0 |
| card_present | input | 1 | Card-presence pin for regions 1 and 2 |
| sdram_wp | input | 2 | Write protect per SDRAM device |
| hready_out | output | 1 | Slave ready |
| hresp | output | 1 | 1 = error response |
| dn_req | output | 1 | Single-cycle request to the downstream controller |
| dn_sel | output | 4 | One-hot region select for the downstream request |
| dn_addr | output | ADDR_W | Address of the forwarded transfer |
| dn_write | output | 1 | Direction of the forwarded transfer |

## Verification
The bench runs a small configuration and sweeps every combination of region enables, flash enable, card presence and write-protect bits. It applies reads and writes to every region, and in the SDRAM region it uses offsets on both sides of the reserved boundary. A wrong priority between rules, or a write-protect check that also catches reads, would turn allowed SDRAM reads or allowed card accesses into errors. An off-by-one in the hole comparison would either let the first reserved offset through or reject the last valid one. Transfers placed in the second error cycle catch a response machine that ignores a new address phase there. IDLE and BUSY transfers aimed at disabled regions catch checking that wrongly applies to non-transfers.

// File: rtl/memacc_pkg.sv
package memacc_pkg;

    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = 2;
    localparam int WP_W      = 2;

    typedef logic [BANK_W-1:0] bank_idx_t;

    localparam bank_idx_t BANK_NOR    = 2'd0;
    localparam bank_idx_t BANK_CARD_A = 2'd1;
    localparam bank_idx_t BANK_CARD_B = 2'd2;
    localparam bank_idx_t BANK_SDRAM  = 2'd3;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } htrans_e;

    typedef enum logic [1:0] {
        RSP_OK       = 2'd0,
        RSP_ERR_WAIT = 2'd1,
        RSP_ERR_DONE = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/memacc_decode.sv
module memacc_decode
    import memacc_pkg::*;
#(
    parameter int REGION_LSB      = 28,
    parameter int SDRAM_DEV_BYTES = 64 * 1024 * 1024
) (
    input  logic [REGION_LSB+1:0] addr_low,
    output bank_idx_t             bank,
    output logic                  sdram_dev,
    output logic                  in_hole
);
    localparam int OFF_W = REGION_LSB - 1;
    localparam logic [REGION_LSB-1:0] DEV_LIMIT = REGION_LSB'(SDRAM_DEV_BYTES);

    logic [OFF_W-1:0] offset;

    always_comb begin
        bank      = addr_low[REGION_LSB+1:REGION_LSB];
        sdram_dev = addr_low[REGION_LSB-1];
        offset    = addr_low[OFF_W-1:0];
        // a hole exists only past the populated part of an SDRAM device window
        in_hole   = (bank == BANK_SDRAM) && ({1'b0, offset} >= DEV_LIMIT);
    end

endmodule

// File: rtl/memacc_rules.sv
module memacc_rules
    import memacc_pkg::*;
(
    input  bank_idx_t             bank,
    input  logic                  sdram_dev,
    input  logic                  in_hole,
    input  logic                  is_write,
    input  logic [NUM_BANKS-1:0]  bank_en,
    input  logic                  flash_acc_en,
    input  logic                  card_present,
    input  logic [WP_W-1:0]       sdram_wp,
    output logic                  reject
);
    logic [NUM_BANKS-1:0] veto;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        if (b == int'(BANK_NOR)) begin : g_nor
            assign veto[b] = !bank_en[b] || !flash_acc_en;
        end else if (b == int'(BANK_SDRAM)) begin : g_sdram
            assign veto[b] = !bank_en[b] || in_hole ||
                             (is_write && sdram_wp[sdram_dev]);
        end else begin : g_card
            assign veto[b] = !bank_en[b] || !card_present;
        end
    end

    always_comb begin
        reject = veto[bank];
    end

endmodule

// File: rtl/memacc_guard.sv
module memacc_guard
    import memacc_pkg::*;
#(
    parameter int ADDR_W          = 32,
    parameter int REGION_LSB      = 28,
    parameter int SDRAM_DEV_BYTES = 64 * 1024 * 1024
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hsel,
    input  logic [1:0]           htrans,
    input  logic [ADDR_W-1:0]    haddr,
    input  logic                 hwrite,
    input  logic                 hready_in,
    input  logic [3:0]           bank_en,
    input  logic                 flash_acc_en,
    input  logic                 card_present,
    input  logic [1:0]           sdram_wp,
    output logic                 hready_out,
    output logic                 hresp,
    output logic                 dn_req,
    output logic [3:0]           dn_sel,
    output logic [ADDR_W-1:0]    dn_addr,
    output logic                 dn_write
);
    typedef struct packed {
        rsp_state_e             rsp;
        logic                   req;
        logic [NUM_BANKS-1:0]   sel;
        logic [ADDR_W-1:0]      addr;
        logic                   write;
    } guard_state_t;

    guard_state_t st_d, st_q;

    bank_idx_t            bank;
    logic                 sdram_dev;
    logic                 in_hole;
    logic                 reject;
    logic                 accept;
    logic [NUM_BANKS-1:0] sel_onehot;

    memacc_decode #(
        .REGION_LSB      (REGION_LSB),
        .SDRAM_DEV_BYTES (SDRAM_DEV_BYTES)
    ) u_decode (
        .addr_low  (haddr[REGION_LSB+1:0]),
        .bank      (bank),
        .sdram_dev (sdram_dev),
        .in_hole   (in_hole)
    );

    memacc_rules u_rules (
        .bank         (bank),
        .sdram_dev    (sdram_dev),
        .in_hole      (in_hole),
        .is_write     (hwrite),
        .bank_en      (bank_en),
        .flash_acc_en (flash_acc_en),
        .card_present (card_present),
        .sdram_wp     (sdram_wp),
        .reject       (reject)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
        assign sel_onehot[b] = (bank == BANK_W'(b));
    end

    always_comb begin
        accept = hsel && hready_in && st_q.rsp != RSP_ERR_WAIT &&
                 (htrans == TR_NONSEQ || htrans == TR_SEQ);

        st_d     = st_q;
        st_d.req = 1'b0;
        st_d.sel = '0;

        if (st_q.rsp == RSP_ERR_WAIT) begin
            st_d.rsp = RSP_ERR_DONE;
        end else begin
            st_d.rsp = RSP_OK;
            if (accept) begin
                if (reject) begin
                    st_d.rsp = RSP_ERR_WAIT;
                end else begin
                    st_d.req   = 1'b1;
                    st_d.sel   = sel_onehot;
                    st_d.addr  = haddr;
                    st_d.write = hwrite;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rsp: RSP_OK, req: 1'b0, sel: '0, addr: '0, write: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign hready_out = (st_q.rsp != RSP_ERR_WAIT);
    assign hresp      = (st_q.rsp != RSP_OK);
    assign dn_req     = st_q.req;
    assign dn_sel     = st_q.sel;
    assign dn_addr    = st_q.addr;
    assign dn_write   = st_q.write;

endmodule

// File: rtl/memacc_guard_chk.sv
module memacc_guard_chk #(
    parameter int ADDR_W          = 32,
    parameter int REGION_LSB      = 28,
    parameter int SDRAM_DEV_BYTES = 64 * 1024 * 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hsel,
    input logic [1:0]        htrans,
    input logic [ADDR_W-1:0] haddr,
    input logic              hwrite,
    input logic              hready_in,
    input logic [3:0]        bank_en,
    input logic              flash_acc_en,
    input logic              card_present,
    input logic [1:0]        sdram_wp,
    input logic              hready_out,
    input logic              hresp,
    input logic              dn_req,
    input logic [3:0]        dn_sel,
    input logic [ADDR_W-1:0] dn_addr,
    input logic              dn_write
);
    logic       acc;
    logic [1:0] bk;
    logic       dv;
    logic       hole;
    logic       exp_rej;
    logic [3:0] exp_sel;

    always_comb begin
        acc     = hsel && hready_in && htrans[1];
        bk      = haddr[REGION_LSB+1:REGION_LSB];
        dv      = haddr[REGION_LSB-1];
        hole    = (bk == 2'd3) && (int'(haddr[REGION_LSB-2:0]) >= SDRAM_DEV_BYTES);
        exp_sel = 4'b0001 << bk;
        exp_rej = !bank_en[bk] ||
                  (bk == 2'd0 && !flash_acc_en) ||
                  ((bk == 2'd1 || bk == 2'd2) && !card_present) ||
                  (bk == 2'd3 && (hole || (hwrite && sdram_wp[dv])));
    end

    p_disabled_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !bank_en[bk]) |=> (hresp && !hready_out));

    p_flash_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && bk == 2'd0 && !flash_acc_en) |=> (hresp && !hready_out));

    p_card_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (bk == 2'd1 || bk == 2'd2) && !card_present) |=> (hresp && !hready_out));

    p_wp_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && bk == 2'd3 && hwrite && sdram_wp[dv]) |=> (hresp && !hready_out));

    p_wp_read_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && bk == 2'd3 && !hwrite && bank_en[3] && !hole) |=> (!hresp && dn_req));

    p_hole_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && hole) |=> (hresp && !hready_out));

    p_err_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && !hready_out) |=> (hresp && hready_out));

    p_err_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hresp) |-> !hready_out);

    p_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hresp |-> (!dn_req && dn_sel == 4'b0000));

    p_idle_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hready_in && hready_out && !(hsel && htrans[1])) |=> (!hresp && hready_out && !dn_req));

    p_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !exp_rej) |=> (dn_req && !hresp && hready_out && dn_sel == $past(exp_sel) &&
                               dn_addr == $past(haddr) && dn_write == $past(hwrite)));

    p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> $onehot0(dn_sel) && dn_sel != 4'b0000);

endmodule

bind memacc_guard memacc_guard_chk #(
    .ADDR_W          (ADDR_W),
    .REGION_LSB      (REGION_LSB),
    .SDRAM_DEV_BYTES (SDRAM_DEV_BYTES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hsel         (hsel),
    .htrans       (htrans),
    .haddr        (haddr),
    .hwrite       (hwrite),
    .hready_in    (hready_in),
    .bank_en      (bank_en),
    .flash_acc_en (flash_acc_en),
    .card_present (card_present),
    .sdram_wp     (sdram_wp),
    .hready_out   (hready_out),
    .hresp        (hresp),
    .dn_req       (dn_req),
    .dn_sel       (dn_sel),
    .dn_addr      (dn_addr),
    .dn_write     (dn_write)
);

// File: tb/memacc_guard_tb.sv
module memacc_guard_tb;

    localparam int AW    = 12;
    localparam int RLSB  = 8;
    localparam int LIMIT = 40;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          hsel;
    logic [1:0]    htrans;
    logic [AW-1:0] haddr;
    logic          hwrite;
    logic          hready_in;
    logic [3:0]    bank_en;
    logic          flash_acc_en;
    logic          card_present;
    logic [1:0]    sdram_wp;
    logic          hready_out;
    logic          hresp;
    logic          dn_req;
    logic [3:0]    dn_sel;
    logic [AW-1:0] dn_addr;
    logic          dn_write;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign hready_in = hready_out;

    memacc_guard #(
        .ADDR_W          (AW),
        .REGION_LSB      (RLSB),
        .SDRAM_DEV_BYTES (LIMIT)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hsel         (hsel),
        .htrans       (htrans),
        .haddr        (haddr),
        .hwrite       (hwrite),
        .hready_in    (hready_in),
        .bank_en      (bank_en),
        .flash_acc_en (flash_acc_en),
        .card_present (card_present),
        .sdram_wp     (sdram_wp),
        .hready_out   (hready_out),
        .hresp        (hresp),
        .dn_req       (dn_req),
        .dn_sel       (dn_sel),
        .dn_addr      (dn_addr),
        .dn_write     (dn_write)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] status();
        return {hresp, hready_out, dn_req, dn_write, dn_sel};
    endfunction

    // {hresp, hready, req, write, sel}
    function automatic logic [7:0] st_vec(input logic r, input logic rdy, input logic q,
                                          input logic w, input logic [3:0] s);
        return {r, rdy, q, w, s};
    endfunction

    // one transfer, address phase driven at a falling edge; checks both following cycles
    task automatic xfer(input logic [1:0] bank, input logic dev, input int off,
                        input logic wr, input string extra);
        logic [AW-1:0] a;
        logic          hole;
        logic          rej;
        string         why;
        a    = {2'b01, bank, dev, 7'(off)};
        hole = (bank == 2'd3) && (off >= LIMIT);
        rej  = 1'b0;
        why  = "R9";
        if (!bank_en[bank]) begin
            rej = 1'b1; why = "R1";
        end else if (bank == 2'd0 && !flash_acc_en) begin
            rej = 1'b1; why = "R2";
        end else if ((bank == 2'd1 || bank == 2'd2) && !card_present) begin
            rej = 1'b1; why = "R3";
        end else if (bank == 2'd3 && hole) begin
            rej = 1'b1; why = "R5";
        end else if (bank == 2'd3 && wr && sdram_wp[dev]) begin
            rej = 1'b1; why = "R4";
        end else if (bank == 2'd3 && !wr && sdram_wp[dev]) begin
            why = "R4 read allowed/R9";
        end
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; haddr = a; hwrite = wr;
        @(posedge clk); #1;
        if (rej) begin
            check({why, "/R6/R7 first error cycle", extra}, 32'(status()),
                  32'(st_vec(1'b1, 1'b0, 1'b0, dn_write, 4'b0000)));
        end else begin
            check({why, " forward", extra}, {status(), 12'(dn_addr)},
                  {st_vec(1'b0, 1'b1, 1'b1, wr, 4'b0001 << bank), 12'(a)});
        end
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00;
        @(posedge clk); #1;
        if (rej) begin
            check({why, "/R6 second error cycle", extra}, 32'({hresp, hready_out, dn_req}),
                  32'(3'b110));
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; hsel = 1'b0; htrans = 2'b00; haddr = '0; hwrite = 1'b0;
        bank_en = 4'hF; flash_acc_en = 1'b1; card_present = 1'b1; sdram_wp = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 reset state", 32'(status()), 32'(st_vec(1'b0, 1'b1, 1'b0, 1'b0, 4'b0000)));

        // R8: non-transfers and unselected transfers to a disabled region
        bank_en = 4'h0;
        for (int t = 0; t < 2; t++) begin
            @(negedge clk);
            hsel = 1'b1; htrans = 2'(t); haddr = {2'b01, 2'd0, 8'h00}; hwrite = 1'b1;
            @(posedge clk); #1;
            check("R8 idle/busy ignored", 32'({hresp, hready_out, dn_req}), 32'(3'b010));
        end
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b10;
        @(posedge clk); #1;
        check("R8 hsel low ignored", 32'({hresp, hready_out, dn_req}), 32'(3'b010));
        @(negedge clk);
        htrans = 2'b00;

        // R11: transfer issued in the second error cycle
        bank_en = 4'b1110;
        xfer(2'd0, 1'b0, 0, 1'b0, "");
        xfer(2'd1, 1'b0, 5, 1'b1, " R11 in second error cycle");
        xfer(2'd0, 1'b0, 0, 1'b1, "");
        xfer(2'd0, 1'b0, 0, 1'b0, " R11 error then error");

        // exhaustive sweep over configuration, regions, direction and hole boundary
        for (int cfg = 0; cfg < 256; cfg++) begin
            @(negedge clk);
            bank_en      = cfg[3:0];
            flash_acc_en = cfg[4];
            card_present = cfg[5];
            sdram_wp     = cfg[7:6];
            for (int wr = 0; wr < 2; wr++) begin
                xfer(2'd0, 1'b1, 17, 1'(wr), "");
                xfer(2'd1, 1'b0, 99, 1'(wr), "");
                xfer(2'd2, 1'b1, 3, 1'(wr), "");
                xfer(2'd3, 1'b0, 0, 1'(wr), "");
                xfer(2'd3, 1'b0, LIMIT - 1, 1'(wr), "");
                xfer(2'd3, 1'b1, LIMIT, 1'(wr), "");
                xfer(2'd3, 1'b1, 127, 1'(wr), "");
            end
        end

        repeat (3) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule